// File: doc/BRIEF.md
# Lockable Instruction Cache with Line Invalidate

This block sits between an instruction fetch unit and a slow backing memory and returns 32-bit instructions. It is read-only and set-associative: 4 ways of 16 sets with 64-byte lines, 4 KiB in total. The fetch address splits into a 6-bit line offset (bits 5:0, with the word index in bits 5:2), a 4-bit set index (bits 9:6) and a 22-bit tag (bits 31:10). A hit answers one cycle after the fetch is accepted. On a miss the block stops accepting fetches. It asks memory for the whole aligned line and takes the line as 16 consecutive 32-bit beats, lowest word first, under a valid/ready handshake. It then answers with the word that was requested.

Each fetch carries a flag from address translation that marks its page as secret. Such a fetch is refused with a fault response before any tag array is read, and it leaves the cache state exactly as it was. Maintenance commands act on the line that holds a given address. They can invalidate it, which is needed after code has been rewritten in memory. They can also lock or unlock it, so that a pinned routine such as an interrupt handler always hits. A locked way is never chosen for replacement. When every way of a set is locked, a miss in that set is served straight from memory with a bypass flag and no line is allocated.

Top module: `lockable_icache`

## Requirements
- R1: A fetch accepted with `fetchSecret`=0 that hits a valid line raises `respValid` on the next clock edge, with `respData` equal to the stored word and no memory request.
- R2: On a miss, `fetchReady` falls. One request goes out for the line-aligned address (offset bits zero), and the line is taken as 16 beats whose data is the words at offsets 0,4,...,60 in that order. The line becomes valid only after the last beat, and `respValid` rises with the requested word on the edge after the last beat is accepted. `respValid` stays low while beats are being received.
- R3: After a refill, a fetch to any of the 16 words of that line hits without a new memory request.
- R4: On a miss in a set with no invalid way, the victim is the least recently used unlocked way, and both hits and refills count as uses.
- R5: `cmdOp`=1 (invalidate) clears the line holding `cmdAddr`, together with its lock. The next fetch to that line misses and refills.
- R6: `cmdOp`=2 (lock) pins a resident line, which is then never replaced. The other ways of the set keep working as a smaller cache.
- R7: A miss in a set whose ways are all locked is served from memory with `respBypass`=1 and allocates nothing, so a repeat fetch misses again. The locked lines still hit.
- R8: A fetch accepted with `fetchSecret`=1 gives `respFault`=1 and `respValid`=0 on the next edge. It issues no memory request and changes no valid, tag or recency state.
- R9: After reset every line is invalid and unlocked, `fetchReady` is high, and `respValid`, `respFault` and `memReqValid` are low.
- R10: `cmdBusy` is high and `fetchReady` low while a refill is in progress. A command is acted on only while `cmdBusy` is low, and it takes precedence over a fetch in the same cycle.
- R11: `cmdOp`=3 (unlock) makes a locked line eligible for replacement again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request present |
| fetchAddr | input | 32 | Fetch byte address |
| fetchSecret | input | 1 | Page of the fetch is tagged secret |
| fetchReady | output | 1 | Fetch is accepted this cycle if valid |
| respValid | output | 1 | Instruction response valid |
| respData | output | 32 | Returned instruction |
| respFault | output | 1 | Fetch refused (secret page) |
| respBypass | output | 1 | Response was served without allocation |
| cmdValid | input | 1 | Maintenance command present |
| cmdOp | input | 2 | 1 invalidate, 2 lock, 3 unlock |
| cmdAddr | input | 32 | Address selecting the target line |
| cmdBusy | output | 1 | Refill in progress, commands held off |
| memReqValid | output | 1 | Line request to memory |
| memReqAddr | output | 32 | Line-aligned request address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Refill beat valid |
| memRspData | input | 32 | Refill beat data |
| memRspReady | output | 1 | Cache takes the beat |

## Verification
The bench builds up a recency order in one set, touches the oldest line and then forces an eviction. A design with FIFO replacement, or one that did not age lines on a hit, would throw out the touched line. It locks the oldest line before a stream of misses, and locks every way of a set. A design that ignored the locks would evict the pinned handler, while one that lacked the bypass path would hang or overwrite a locked way. A secret fetch is aimed at the oldest line just before an eviction, so a design that looked up or aged that line would evict the wrong way. A refill whose requested word is the last beat catches a response raised one beat too early. Memory stalls between beats catch a beat counter that counts cycles instead of accepted beats.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } fc_state_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_INVAL  = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } fc_op_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hitTouch;    // hit accepted: load response, age the set
    logic missAlloc;   // miss accepted: latch miss, clear victim
    logic beatWr;      // refill beat accepted
    logic lastBeat;    // this beat completes the line
    logic invLine;     // invalidate command
    logic lockLine;    // lock command
    logic unlockLine;  // unlock command
    logic bypass;      // current refill allocates nothing
  } fc_strobe_t;

endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int WORDS   = LINE_BYTES / WORD_BYTES,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int WBYTE_W = $clog2(WORD_BYTES),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SET_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchSecret,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  fc_strobe_t        strb,
  input  logic [WIDX_W-1:0] beatIdx,
  input  logic [WORD_W-1:0] memRspData,
  output logic              fetchHit,
  output logic              setAllLocked,
  output logic [WORD_W-1:0] respData,
  output logic [ADDR_W-1:0] lineAddr
);

  localparam int AGE_W = (WAY_W < 1) ? 1 : WAY_W;

  logic [TAG_W-1:0]  tagArr  [SETS][WAYS];
  logic [WORD_W-1:0] dataArr [SETS][WAYS][WORDS];
  logic [WAYS-1:0]   validArr[SETS];
  logic [WAYS-1:0]   lockArr [SETS];
  logic [AGE_W-1:0]  ageArr  [SETS][WAYS];

  logic [SET_W-1:0]  fSet, cSet, missSet, touchSet;
  logic [TAG_W-1:0]  fTag, cTag, missTag;
  logic [WIDX_W-1:0] fWord, missWord;
  logic [WAY_W-1:0]  fHitWay, cHitWay, vicWay, missWay, touchWay;
  logic [WAYS-1:0]   fHitVec, cHitVec;
  logic              cHit, lookupEn, touchEn;
  logic [WORD_W-1:0] hitWord;
  logic              unusedAddrBits;

  assign fSet  = fetchAddr[OFF_W +: SET_W];
  assign fTag  = fetchAddr[ADDR_W-1 -: TAG_W];
  assign fWord = fetchAddr[WBYTE_W +: WIDX_W];
  assign cSet  = cmdAddr[OFF_W +: SET_W];
  assign cTag  = cmdAddr[ADDR_W-1 -: TAG_W];
  assign unusedAddrBits = ^{fetchAddr[WBYTE_W-1:0], cmdAddr[OFF_W-1:0]};

  // secret fetches are gated before any tag compare
  assign lookupEn = fetchValid && !fetchSecret;

  always_comb begin
    fHitWay = '0;
    cHitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      fHitVec[w] = lookupEn && validArr[fSet][w] && (tagArr[fSet][w] == fTag);
      cHitVec[w] = validArr[cSet][w] && (tagArr[cSet][w] == cTag);
      if (fHitVec[w]) fHitWay = WAY_W'(w);
      if (cHitVec[w]) cHitWay = WAY_W'(w);
    end
  end

  assign fetchHit     = |fHitVec;
  assign cHit         = |cHitVec;
  assign hitWord      = dataArr[fSet][fHitWay][fWord];
  assign setAllLocked = &lockArr[fSet];

  // victim: first free unlocked way, else oldest unlocked way
  always_comb begin
    logic found;
    logic haveCand;
    logic [AGE_W-1:0] bestAge;
    vicWay   = '0;
    found    = 1'b0;
    haveCand = 1'b0;
    bestAge  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !validArr[fSet][w] && !lockArr[fSet][w]) begin
        vicWay = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!lockArr[fSet][w] && (!haveCand || ageArr[fSet][w] > bestAge)) begin
          vicWay   = WAY_W'(w);
          bestAge  = ageArr[fSet][w];
          haveCand = 1'b1;
        end
      end
    end
  end

  assign touchEn  = strb.hitTouch || (strb.lastBeat && !strb.bypass);
  assign touchSet = strb.hitTouch ? fSet : missSet;
  assign touchWay = strb.hitTouch ? fHitWay : missWay;

  // control state: valid, lock and recency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        lockArr[s]  <= '0;
        for (int w = 0; w < WAYS; w++) ageArr[s][w] <= AGE_W'(w);
      end
    end else begin
      if (strb.missAlloc && !setAllLocked) validArr[fSet][vicWay] <= 1'b0;
      if (strb.lastBeat && !strb.bypass) validArr[missSet][missWay] <= 1'b1;
      if (strb.invLine && cHit) begin
        validArr[cSet][cHitWay] <= 1'b0;
        lockArr[cSet][cHitWay]  <= 1'b0;
      end
      if (strb.lockLine && cHit)   lockArr[cSet][cHitWay] <= 1'b1;
      if (strb.unlockLine && cHit) lockArr[cSet][cHitWay] <= 1'b0;
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ageArr[touchSet][w] < ageArr[touchSet][touchWay])
            ageArr[touchSet][w] <= ageArr[touchSet][w] + AGE_W'(1);
        end
        ageArr[touchSet][touchWay] <= '0;
      end
    end
  end

  // storage and miss context, no reset needed
  always_ff @(posedge clk) begin
    if (strb.missAlloc) begin
      missSet  <= fSet;
      missTag  <= fTag;
      missWord <= fWord;
      missWay  <= vicWay;
      if (!setAllLocked) tagArr[fSet][vicWay] <= fTag;
    end
    if (strb.beatWr && !strb.bypass)
      dataArr[missSet][missWay][beatIdx] <= memRspData;
    if (strb.hitTouch)
      respData <= hitWord;
    else if (strb.beatWr && beatIdx == missWord)
      respData <= memRspData;
  end

  assign lineAddr = {missTag, missSet, {OFF_W{1'b0}}};

  // R1: at most one way can match a fetch
  p_single_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fHitVec));

  // R2: the line is not usable before its last beat arrived
  p_valid_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.beatWr && !strb.lastBeat && !strb.bypass) |=> !validArr[missSet][missWay]);

  // R5: an invalidated line is gone on the next cycle
  p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invLine && cHit) |=> !validArr[$past(cSet)][$past(cHitWay)]);

  // R6: an allocating miss never lands on a locked way
  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.missAlloc && !setAllLocked) |-> !lockArr[fSet][vicWay]);

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  localparam int WORDS  = LINE_BYTES / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic              fetchSecret,
  output logic              fetchReady,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  output logic              cmdBusy,
  input  logic              fetchHit,
  input  logic              setAllLocked,
  output logic              memReqValid,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              memRspReady,
  output logic              respValid,
  output logic              respFault,
  output logic              respBypass,
  output fc_strobe_t        strb,
  output logic [WIDX_W-1:0] beatIdx
);

  fc_state_t         state, nextState;
  logic [WIDX_W-1:0] beatCnt;
  logic              bypassQ;
  logic              accept;

  assign fetchReady  = (state == ST_IDLE) && !cmdValid;
  assign cmdBusy     = (state != ST_IDLE);
  assign accept      = fetchValid && fetchReady;
  assign memReqValid = (state == ST_REQ);
  assign memRspReady = (state == ST_FILL);
  assign beatIdx     = beatCnt;

  always_comb begin
    strb        = '0;
    strb.bypass = bypassQ;
    nextState   = state;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (fc_op_t'(cmdOp))
            OP_INVAL:  strb.invLine    = 1'b1;
            OP_LOCK:   strb.lockLine   = 1'b1;
            OP_UNLOCK: strb.unlockLine = 1'b1;
            default: ;
          endcase
        end else if (accept && !fetchSecret) begin
          if (fetchHit) begin
            strb.hitTouch = 1'b1;
          end else begin
            strb.missAlloc = 1'b1;
            strb.bypass    = setAllLocked;
            nextState      = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (memReqReady) nextState = ST_FILL;
      end
      ST_FILL: begin
        if (memRspValid) begin
          strb.beatWr = 1'b1;
          if (beatCnt == WIDX_W'(WORDS - 1)) begin
            strb.lastBeat = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatCnt    <= '0;
      bypassQ    <= 1'b0;
      respValid  <= 1'b0;
      respFault  <= 1'b0;
      respBypass <= 1'b0;
    end else begin
      state      <= nextState;
      respValid  <= strb.hitTouch || strb.lastBeat;
      respFault  <= accept && fetchSecret;
      respBypass <= strb.lastBeat && bypassQ;
      if (strb.missAlloc) begin
        bypassQ <= setAllLocked;
        beatCnt <= '0;
      end else if (strb.beatWr) begin
        beatCnt <= beatCnt + WIDX_W'(1);
      end
    end
  end

  // R1: a clean hit answers on the next edge without bypass
  p_hit_answer_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !fetchSecret && fetchHit) |=> (respValid && !respBypass));

  // R2: no instruction leaves the cache while beats are streaming in
  p_no_resp_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRspReady |-> !respValid);

  // R2: the last beat is followed by the response
  p_resp_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && memRspReady && beatCnt == WIDX_W'(WORDS - 1)) |=> respValid);

  // R8: a secret fetch faults and starts no memory traffic
  p_secret_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && fetchSecret) |=> (respFault && !respValid && !memReqValid));

  // R10: fetches are held while a refill owns the cache
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |-> !fetchReady);

endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import fc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int WIDX_W = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchSecret,
  output logic              fetchReady,
  output logic              respValid,
  output logic [WORD_W-1:0] respData,
  output logic              respFault,
  output logic              respBypass,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdBusy,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic              memRspReady
);

  fc_strobe_t        strb;
  logic [WIDX_W-1:0] beatIdx;
  logic              fetchHit;
  logic              setAllLocked;

  fc_ctrl #(
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .fetchSecret  (fetchSecret),
    .fetchReady   (fetchReady),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .cmdBusy      (cmdBusy),
    .fetchHit     (fetchHit),
    .setAllLocked (setAllLocked),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .memRspReady  (memRspReady),
    .respValid    (respValid),
    .respFault    (respFault),
    .respBypass   (respBypass),
    .strb         (strb),
    .beatIdx      (beatIdx)
  );

  fc_datapath #(
    .ADDR_W    (ADDR_W),
    .WAYS      (WAYS),
    .SETS      (SETS),
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .fetchAddr    (fetchAddr),
    .fetchSecret  (fetchSecret),
    .cmdAddr      (cmdAddr),
    .strb         (strb),
    .beatIdx      (beatIdx),
    .memRspData   (memRspData),
    .fetchHit     (fetchHit),
    .setAllLocked (setAllLocked),
    .respData     (respData),
    .lineAddr     (memReqAddr)
  );

endmodule

// File: tb/lockable_icache_bench.sv
module lockable_icache_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid, fetchSecret, fetchReady;
  logic [31:0] fetchAddr;
  logic        respValid, respFault, respBypass;
  logic [31:0] respData;
  logic        cmdValid, cmdBusy;
  logic [1:0]  cmdOp;
  logic [31:0] cmdAddr;
  logic        memReqValid, memReqReady, memRspValid, memRspReady;
  logic [31:0] memReqAddr, memRspData;

  int total = 0;
  int bad   = 0;
  int reqCount = 0;
  logic [31:0] lastReqAddr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lockable_icache u_lockable_icache (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchSecret(fetchSecret),
    .fetchReady(fetchReady), .respValid(respValid), .respData(respData),
    .respFault(respFault), .respBypass(respBypass),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdBusy(cmdBusy),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspReady(memRspReady)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h3C5A_0F00;
  endfunction

  function automatic logic [31:0] addrOf(input int tag, input int set, input int word);
    return (32'(tag) << 10) | (32'(set) << 6) | (32'(word) << 2);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // backing memory: line request, then 16 beats with two stall gaps
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (2) @(negedge clk);
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        lastReqAddr = memReqAddr;
        reqCount++;
        for (int b = 0; b < 16; b++) begin
          if (b == 5 || b == 11) begin
            memRspValid = 1'b0;
            @(negedge clk);
          end
          memRspValid = 1'b1;
          memRspData  = memWord(lastReqAddr + 32'(b * 4));
          @(negedge clk);
        end
        memRspValid = 1'b0;
      end
    end
  end

  task automatic doFetch(input logic [31:0] a, input logic sec,
                         output logic [31:0] data, output logic fault, output logic valid,
                         output logic byp, output int lat, output int reqs, output logic sawBusy);
    int r0;
    r0 = reqCount;
    @(negedge clk);
    while (!fetchReady) @(negedge clk);
    fetchValid  = 1'b1;
    fetchAddr   = a;
    fetchSecret = sec;
    @(negedge clk);
    fetchValid  = 1'b0;
    fetchSecret = 1'b0;
    lat = 1;
    sawBusy = 1'b0;
    while (!(respValid || respFault) && lat < 400) begin
      if (cmdBusy && !fetchReady) sawBusy = 1'b1;
      @(negedge clk);
      lat++;
    end
    data  = respData;
    fault = respFault;
    valid = respValid;
    byp   = respBypass;
    reqs  = reqCount - r0;
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    while (cmdBusy) @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdAddr  = a;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp    = 2'd0;
  endtask

  task automatic expectHit(input logic [31:0] a, input string req);
    logic [31:0] d; logic f, v, b, s; int lat, reqs;
    doFetch(a, 1'b0, d, f, v, b, lat, reqs, s);
    check(v && lat == 1, req, "hit latency", 32'(lat), 32'd1);
    check(reqs == 0, req, "hit mem requests", 32'(reqs), 32'd0);
    check(d == memWord(a), req, "hit data", d, memWord(a));
  endtask

  task automatic expectMiss(input logic [31:0] a, input logic expByp, input string req);
    logic [31:0] d; logic f, v, b, s; int lat, reqs;
    doFetch(a, 1'b0, d, f, v, b, lat, reqs, s);
    check(v && lat > 16, req, "miss latency", 32'(lat), 32'd17);
    check(reqs == 1, req, "miss mem requests", 32'(reqs), 32'd1);
    check(lastReqAddr == {a[31:6], 6'd0}, req, "line address", lastReqAddr, {a[31:6], 6'd0});
    check(d == memWord(a), req, "miss data", d, memWord(a));
    check(b == expByp, req, "bypass flag", 32'(b), 32'(expByp));
  endtask

  task automatic fillSet(input int set);
    for (int t = 1; t <= 4; t++) expectMiss(addrOf(t, set, 0), 1'b0, "R4");
  endtask

  task automatic testReset();
    check(fetchReady == 1'b1, "R9", "fetchReady after reset", 32'(fetchReady), 32'd1);
    check(respValid == 1'b0 && respFault == 1'b0, "R9", "no response after reset",
          32'({respValid, respFault}), 32'd0);
    check(memReqValid == 1'b0 && cmdBusy == 1'b0, "R9", "idle memory side",
          32'({memReqValid, cmdBusy}), 32'd0);
  endtask

  task automatic testFirstMiss();
    logic [31:0] d; logic f, v, b, s; int lat, reqs;
    doFetch(addrOf(1, 3, 5), 1'b0, d, f, v, b, lat, reqs, s);
    check(reqs == 1, "R9", "empty cache misses", 32'(reqs), 32'd1);
    check(lastReqAddr == addrOf(1, 3, 0), "R2", "aligned request", lastReqAddr, addrOf(1, 3, 0));
    check(v && d == memWord(addrOf(1, 3, 5)), "R2", "requested word", d, memWord(addrOf(1, 3, 5)));
    check(lat > 16, "R2", "stall through refill", 32'(lat), 32'd17);
    check(s, "R10", "busy and not ready during refill", 32'(s), 32'd1);
  endtask

  task automatic testWholeLine();
    for (int w = 0; w < 16; w++) expectHit(addrOf(1, 3, w), "R3");
  endtask

  task automatic testLru();
    fillSet(5);
    expectHit(addrOf(1, 5, 4), "R4");
    expectMiss(addrOf(5, 5, 1), 1'b0, "R4");
    expectHit(addrOf(1, 5, 2), "R4");
    expectHit(addrOf(3, 5, 2), "R4");
    expectHit(addrOf(4, 5, 2), "R4");
    expectHit(addrOf(5, 5, 2), "R4");
    expectMiss(addrOf(2, 5, 3), 1'b0, "R4");
  endtask

  task automatic testInvalidate();
    doCmd(2'd1, addrOf(1, 3, 9));
    expectMiss(addrOf(1, 3, 2), 1'b0, "R5");
    expectHit(addrOf(1, 3, 8), "R5");
  endtask

  task automatic testLock();
    fillSet(7);
    doCmd(2'd2, addrOf(1, 7, 0));
    for (int t = 5; t <= 8; t++) expectMiss(addrOf(t, 7, 3), 1'b0, "R6");
    expectHit(addrOf(1, 7, 6), "R6");
    expectHit(addrOf(8, 7, 6), "R6");
    expectMiss(addrOf(5, 7, 6), 1'b0, "R6");
  endtask

  task automatic testAllLocked();
    fillSet(9);
    for (int t = 1; t <= 4; t++) doCmd(2'd2, addrOf(t, 9, 0));
    expectMiss(addrOf(5, 9, 7), 1'b1, "R7");
    expectMiss(addrOf(5, 9, 15), 1'b1, "R7");
    for (int t = 1; t <= 4; t++) expectHit(addrOf(t, 9, 10), "R7");
  endtask

  task automatic testUnlock();
    doCmd(2'd3, addrOf(2, 9, 0));
    expectMiss(addrOf(6, 9, 0), 1'b0, "R11");
    expectMiss(addrOf(2, 9, 0), 1'b0, "R11");
    expectHit(addrOf(1, 9, 0), "R11");
  endtask

  task automatic testSecret();
    logic [31:0] d; logic f, v, b, s; int lat, reqs;
    fillSet(11);
    doFetch(addrOf(1, 11, 0), 1'b1, d, f, v, b, lat, reqs, s);
    check(f && !v && lat == 1, "R8", "fault on resident secret line",
          32'({f, v}), 32'b10);
    check(reqs == 0, "R8", "no request on secret", 32'(reqs), 32'd0);
    doFetch(addrOf(9, 11, 0), 1'b1, d, f, v, b, lat, reqs, s);
    check(f && !v && reqs == 0, "R8", "fault on absent secret line",
          32'({f, v, 30'(reqs)}), 32'h8000_0000);
    expectMiss(addrOf(5, 11, 0), 1'b0, "R8");
    expectHit(addrOf(2, 11, 0), "R8");
    expectMiss(addrOf(1, 11, 0), 1'b0, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    fetchValid = 1'b0; fetchSecret = 1'b0; fetchAddr = '0;
    cmdValid = 1'b0; cmdOp = 2'd0; cmdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstMiss();
    testWholeLine();
    testLru();
    testInvalidate();
    testLock();
    testAllLocked();
    testUnlock();
    testSecret();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule